// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed N-bit operands and returns their signed 2N-bit product. It uses a single adder/subtractor over several clock cycles. Each cycle it looks at an overlapping three-bit window of the multiplier and picks one multiple of the multiplicand: zero, plus or minus X, or plus or minus 2X. It adds that multiple to a running partial product, or subtracts it. It then shifts the partial product and the multiplier two places to the right, with sign extension. The window's lowest bit is the multiplier bit that the previous step shifted out. An implied zero stands in that place for the first step. An operation therefore takes N/2 arithmetic steps, not N.

A caller holds the operands on the inputs and raises `start` for one cycle while the block is idle. `busy` stays high while the steps run. `done` pulses for one cycle when the product register is written. The product then holds its value until the next operation completes. When N is odd, the multiplier is sign-extended by one bit, so the step count becomes (N+1)/2.

Top module: `booth_mul`

## Requirements
- R1: While reset is asserted (`rst_n` low), `busy` and `done` are 0 and `product` is 0.
- R2: A `start` pulse sampled while `busy` is 0 makes `busy` read 1 after that clock edge.
- R3: After an accepted start, `busy` stays high for exactly S = ceil(N/2) cycles. On the edge that ends the last step, `busy` falls and `done` rises.
- R4: When `done` is 1, `product` equals the two's-complement product of the multiplicand and multiplier sampled with the accepted start. This includes the most negative value on either operand and on both.
- R5: A `start` raised while `busy` is 1 is ignored. The running operation finishes at its original time with its original result, and no further operation begins.
- R6: `product` changes only on the cycle that `done` is asserted. Between operations it holds the last result.
- R7: `done` is high for exactly one cycle per completed operation.
- R8: For odd N the multiplier is sign-extended by one bit. The products are exact for every operand pair, and the operation takes (N+1)/2 steps.
- R9: Each step selects the multiple from the window {y[i+1], y[i], y[i-1]} as follows: 000 and 111 give 0, 001 and 010 give +X, 011 gives +2X, 100 gives -2X, and 101 and 110 give -X. For example, with N=8 the multiplier 0x07 times the multiplicand 9 gives 63, through -X followed by +2X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| mcand | input | N | Signed multiplicand X |
| mplier | input | N | Signed multiplier Y |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: product just written |
| product | output | 2N | Signed product of the last completed operation |

## Verification
A wrong recoding choice, a missing sign extension on the shift, or a misrouted carry-in on subtraction corrupts `product`. That error appears on the first `done` after the faulty step, which is at most S cycles after start. Operand pairs are chosen so that every window code and every most-negative value is used. Doing so ensures that each multiple selection reaches a compared product. A step counter that is off by one appears at once as a `busy` length other than S. A faulty idle guard appears as an extra `done` or a changed result after a start raised while busy.

// File: rtl/booth_pkg.sv
package booth_pkg;
    // Multiple selected by one recoding window
    typedef struct packed {
        logic zero;   // multiple is 0
        logic two;    // magnitude is 2X (else X)
        logic neg;    // subtract the multiple
    } booth_sel_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic [2:0]  grp,
    output booth_sel_t  sel
);
    always_comb begin
        sel.zero = (grp == 3'b000) || (grp == 3'b111);
        sel.two  = (grp == 3'b011) || (grp == 3'b100);
        sel.neg  = grp[2] && !(grp[1] && grp[0]);
    end
endmodule

// File: rtl/booth_multiple.sv
module booth_multiple
    import booth_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] x,
    input  booth_sel_t   sel,
    output logic [W-1:0] mult
);
    always_comb begin
        if (sel.zero)
            mult = '0;
        else if (sel.two)
            mult = {x[W-2:0], 1'b0};
        else
            mult = x;
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] b_x;
    always_comb begin
        b_x = b ^ {W{sub}};
        sum = a + b_x + W'(sub);
    end
endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N-1:0]     mcand,
    input  logic [N-1:0]     mplier,
    output logic             busy,
    output logic             done,
    output logic [2*N-1:0]   product
);
    localparam int NE = N + (N % 2);       // even multiplier width
    localparam int S  = NE / 2;            // step count
    localparam int W  = NE + 2;            // accumulator width
    localparam int CW = $clog2(S + 1);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [CW-1:0]   cnt;
        logic [W-1:0]    acc;
        logic [NE-1:0]   mq;
        logic            qm1;
        logic [W-1:0]    x;
        logic [2*N-1:0]  prod;
    } state_t;

    state_t s_d, s_q;

    booth_sel_t      sel;
    logic [W-1:0]    mult;
    logic [W-1:0]    sum;
    logic [W-1:0]    acc_sh;
    logic [NE-1:0]   mq_sh;
    logic [W+NE-1:0] full;

    booth_recode u_rec (
        .grp ({s_q.mq[1:0], s_q.qm1}),
        .sel (sel)
    );

    booth_multiple #(.W(W)) u_mult (
        .x    (s_q.x),
        .sel  (sel),
        .mult (mult)
    );

    booth_addsub #(.W(W)) u_add (
        .a   (s_q.acc),
        .b   (mult),
        .sub (sel.neg && !sel.zero),
        .sum (sum)
    );

    always_comb begin
        acc_sh = {{2{sum[W-1]}}, sum[W-1:2]};
        mq_sh  = {sum[1:0], s_q.mq[NE-1:2]};
        full   = {acc_sh, mq_sh};

        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.cnt  = CW'(S);
                s_d.acc  = '0;
                s_d.mq   = NE'($signed(mplier));
                s_d.qm1  = 1'b0;
                s_d.x    = W'($signed(mcand));
            end
        end else begin
            s_d.acc = acc_sh;
            s_d.mq  = mq_sh;
            s_d.qm1 = s_q.mq[1];
            s_d.cnt = s_q.cnt - CW'(1);
            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.prod = full[2*N-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign product = s_q.prod;
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int S  = (N + (N % 2)) / 2;
    localparam int CW = $clog2(S + 2);

    logic signed [2*N-1:0] exp_q;
    logic [CW-1:0]         bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            bcnt  <= '0;
        end else begin
            if (start && !busy)
                exp_q <= $signed(mcand) * $signed(mplier);
            bcnt <= busy ? bcnt + CW'(1) : '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!busy && !done && product == '0)); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (bcnt < CW'(S))); // R3
    AST_DONE_AFTER_S: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(bcnt) == CW'(S - 1))); // R3
    AST_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n) done |-> (product == exp_q)); // R4
    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(product)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
endmodule

bind booth_mul booth_mul_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_mul_bench.sv
`timescale 1ns/1ps
module booth_mul_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;

    // N = 8 instance
    logic        start8 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic        busy8, done8;
    logic [15:0] prod8;

    // N = 5 instance (odd width)
    logic        start5 = 1'b0;
    logic [4:0]  a5 = '0, b5 = '0;
    logic        busy5, done5;
    logic [9:0]  prod5;

    booth_mul #(.N(8)) u_booth_mul (
        .clk(clk), .rst_n(rst_n), .start(start8), .mcand(a8), .mplier(b8),
        .busy(busy8), .done(done8), .product(prod8));

    booth_mul #(.N(5)) u_booth_mul_odd (
        .clk(clk), .rst_n(rst_n), .start(start5), .mcand(a5), .mplier(b5),
        .busy(busy5), .done(done5), .product(prod5));

    logic [15:0] q8[$];
    logic [9:0]  q5[$];
    logic [15:0] last8 = '0;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done8) begin
                if (q8.size() == 0) check(1'b0, "R5 unexpected done8", 1, 0);
                else begin
                    logic [15:0] e;
                    e = q8.pop_front();
                    check(prod8 == e, "R4 product8", prod8, e);
                end
            end
            if (done5) begin
                if (q5.size() == 0) check(1'b0, "R5 unexpected done5", 1, 0);
                else begin
                    logic [9:0] e;
                    e = q5.pop_front();
                    check(prod5 == e, "R8 product5", prod5, e);
                end
            end
        end
    end

    // driver for N=8; poke=1 raises start again while busy (R5)
    task automatic op8(input logic [7:0] a, input logic [7:0] b, input bit poke);
        logic signed [15:0] e;
        int cyc;
        e = $signed(a) * $signed(b);
        @(negedge clk);
        a8 = a; b8 = b; start8 = 1'b1;
        q8.push_back(e);
        @(negedge clk);
        start8 = 1'b0;
        check(busy8 == 1'b1, "R2 busy8 after start", busy8, 1);
        cyc = 0;
        while (!done8 && cyc < 20) begin
            if (poke && cyc == 1) begin
                a8 = 8'h7f; b8 = 8'h81; start8 = 1'b1;
            end else start8 = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start8 = 1'b0;
        check(cyc == 4, "R3 busy8 length", cyc, 4);
        check(busy8 == 1'b0, "R3 busy8 low at done", busy8, 0);
        last8 = e;
        @(negedge clk);
        check(done8 == 1'b0, "R7 done8 single cycle", done8, 0);
        if (poke) check(busy8 == 1'b0, "R5 no restart from poke", busy8, 0);
    endtask

    task automatic op5(input logic [4:0] a, input logic [4:0] b);
        logic signed [9:0] e;
        int cyc;
        e = $signed(a) * $signed(b);
        @(negedge clk);
        a5 = a; b5 = b; start5 = 1'b1;
        q5.push_back(e);
        @(negedge clk);
        start5 = 1'b0;
        cyc = 0;
        while (!done5 && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 3, "R8 busy5 length", cyc, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R3 watchdog timeout", 0, 1);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        @(negedge clk);
        @(negedge clk);
        check(busy8 == 0 && done8 == 0, "R1 reset ctrl8", {busy8, done8}, 0);
        check(prod8 == 0, "R1 reset product8", prod8, 0);
        check(busy5 == 0 && done5 == 0 && prod5 == 0, "R1 reset odd", {busy5, done5, prod5}, 0);
        rst_n = 1'b1;

        // R9: 9 * 7 = 63 (windows 110 -> -X, 011 -> +2X)
        op8(8'd9, 8'd7, 1'b0);
        check(prod8 == 16'd63, "R9 example 9x7", prod8, 63);
        // every window code: 0x9c = 1001_1100 -> 000,110,011,100 ; 0x2a -> 100,101,101,001
        op8(8'h13, 8'h9c, 1'b0);
        op8(8'hed, 8'h2a, 1'b0);
        op8(8'h55, 8'hb6, 1'b0);
        op8(8'h80, 8'h80, 1'b0);
        op8(8'h80, 8'h7f, 1'b0);
        op8(8'h7f, 8'h80, 1'b0);
        op8(8'hff, 8'hff, 1'b0);
        op8(8'h00, 8'h80, 1'b0);
        op8(8'h7f, 8'h7f, 1'b0);
        op8(8'h80, 8'hff, 1'b0);

        // R5: start while busy ignored
        op8(8'hc3, 8'h5a, 1'b1);

        // R6: product holds between operations
        repeat (3) @(negedge clk);
        check(prod8 == last8, "R6 product8 holds", prod8, last8);

        for (int k = 0; k < 300; k++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            op8(seed[31:24], seed[15:8], 1'b0);
        end

        // R8: exhaustive odd width
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++)
                op5(5'(i), 5'(j));

        repeat (3) @(negedge clk);
        check(q8.size() == 0 && q5.size() == 0, "R4 scoreboard drained", q8.size() + q5.size(), 0);
        summary();
        $finish;
    end
endmodule